// File: doc/BRIEF.md
# Ring and Johnson Shift Counter

This block is a small shift-based counter. It moves through a fixed cycle of bit patterns without any binary decoding. The state is a chain of D flip-flops. On every clock edge each stage takes the value of the stage before it. One mode input chooses what the head of the chain receives from the tail stage. In ring mode it receives the tail value unchanged, so a single one circulates through 4 states. In Johnson mode it receives the inverted tail value, so the pattern fills with ones and then drains over 8 states.

The counter gives the intended sequence only after it holds a pattern that belongs to the cycle. An active-low synchronous reset and a synchronous initialize input both load the starting pattern 1000 (bit 3 set), and the counter then steps from there. A change of mode applies from the next clock edge onward. The register is never corrected automatically, so a legal ring pattern is only guaranteed after a fresh initialize.

Top module: `shift_cnt_top`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `count_o` becomes 4'b1000 after that edge.
- R2: When `init` is high at a rising edge (with `rst_n` high), `count_o` becomes 4'b1000 after that edge, whatever the mode and the previous state.
- R3: At each rising edge with `rst_n` high and `init` low, `count_o[2:0]` takes the previous `count_o[3:1]`, so the pattern shifts toward bit 0.
- R4: With `mode_i` = 0 (ring), `count_o[3]` takes the previous `count_o[0]`. Starting from 1000, the sequence is 1000, 0100, 0010, 0001 and then repeats.
- R5: With `mode_i` = 1 (Johnson), `count_o[3]` takes the inverse of the previous `count_o[0]`. Starting from 1000, the sequence is 1000, 1100, 1110, 1111, 0111, 0011, 0001, 0000 and then repeats.
- R6: A change of `mode_i` takes effect at the first rising edge at which the new value is present. For example, from 0001 in ring mode, switching to Johnson gives 0000 at the next edge.
- R7: `count_o` changes only at rising clock edges. An input change between edges leaves it unchanged until the next edge.
- R8: In ring mode without initialize, the number of ones in `count_o` is preserved from one edge to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes at its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads 1000 |
| init | input | 1 | Synchronous initialize; loads 1000 |
| mode_i | input | 1 | Feedback select: 0 = ring, 1 = Johnson (inverted feedback) |
| count_o | output | 4 | Current counter pattern, bit 3 is the head stage |

## Verification
Every bit of the state is visible directly on `count_o`. A wrong internal value therefore appears at the ports in the same cycle it is produced. A fault in the shift path or the feedback path shows up one edge after the faulty stage loads. A wrong starting pattern causes the ring sequence to lose or duplicate its single one, and it pushes the Johnson sequence off its 8-state cycle within a few edges. The bench therefore compares every cycle against a model built from the requirements. It also checks that the pattern holds between edges when inputs move mid-cycle.

// File: rtl/shift_cnt_pkg.sv
// Package: shared types and helpers for the shift counter.
// Assumes the head stage is the most significant bit of the state.
package shift_cnt_pkg;

    // Feedback topology selected by the mode input.
    typedef enum logic {
        MODE_RING  = 1'b0,
        MODE_TWIST = 1'b1
    } shift_mode_e;

    // Starting pattern: only the head stage set.
    function automatic logic [31:0] seed_word(input int unsigned width);
        seed_word = 32'd1 << (width - 1);
    endfunction

endpackage

// File: rtl/shift_cnt_stage.sv
// Module: one storage stage of the shift chain.
// Loads its seed bit on reset or initialize, otherwise takes d each edge.
// Assumes rst_n and init are synchronous to clk.
module shift_cnt_stage #(
    parameter logic SEED_BIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic d,
    output logic q
);

    // Stage register: seed on reset/initialize, shift otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            q <= SEED_BIT;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/shift_cnt_feedback.sv
// Module: feedback path from the tail stage to the head stage.
// Ring mode passes the tail through; twisted mode inverts it.
// Assumes the tail stage is bit 0 of the state.
module shift_cnt_feedback #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0]             state,
    input  shift_cnt_pkg::shift_mode_e   mode,
    output logic                         head_d
);

    import shift_cnt_pkg::*;

    // Select the head input from the tail according to mode.
    always_comb begin
        unique case (mode)
            MODE_TWIST: head_d = ~state[0];
            default:    head_d = state[0];
        endcase
    end

endmodule

// File: rtl/shift_cnt_top.sv
// Module: ring / Johnson shift counter top.
// A chain of WIDTH stages shifts toward bit 0. The head stage (bit WIDTH-1)
// is fed from the tail through the mode-selected feedback.
// Assumes the counter is initialized before its sequence is relied on.
module shift_cnt_top #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             mode_i,
    output logic [WIDTH-1:0] count_o
);

    import shift_cnt_pkg::*;

    localparam logic [WIDTH-1:0] SEED = WIDTH'(seed_word(WIDTH));

    shift_mode_e       mode;
    logic              head_d;
    logic [WIDTH-1:0]  stage_d;
    logic [WIDTH-1:0]  stage_q;

    // Map the raw mode pin onto the enumerated type.
    always_comb mode = shift_mode_e'(mode_i);

    shift_cnt_feedback #(.WIDTH(WIDTH)) u_fb (
        .state  (stage_q),
        .mode   (mode),
        .head_d (head_d)
    );

    // Build the chain: head from feedback, each other stage from its upper neighbour.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == WIDTH - 1) begin : g_head
            assign stage_d[i] = head_d;
        end else begin : g_body
            assign stage_d[i] = stage_q[i+1];
        end

        shift_cnt_stage #(.SEED_BIT(SEED[i])) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .init  (init),
            .d     (stage_d[i]),
            .q     (stage_q[i])
        );
    end

    assign count_o = stage_q;

endmodule

// File: rtl/shift_cnt_checker.sv
// Module: assertion checker for shift_cnt_top, attached by bind below.
// Assumes synchronous active-low reset; all properties are disabled under it.
module shift_cnt_checker #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init,
    input logic             mode_i,
    input logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] SEED = WIDTH'(shift_cnt_pkg::seed_word(WIDTH));

    AST_INIT_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> count_o == SEED); // R2

    AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> count_o[WIDTH-2:0] == $past(count_o[WIDTH-1:1])); // R3

    AST_RING_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !mode_i) |=> count_o[WIDTH-1] == $past(count_o[0])); // R4

    AST_TWIST_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && mode_i) |=> count_o[WIDTH-1] != $past(count_o[0])); // R5

    AST_RING_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !mode_i) |=> $countones(count_o) == $countones($past(count_o))); // R8

endmodule

bind shift_cnt_top shift_cnt_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (init),
    .mode_i  (mode_i),
    .count_o (count_o)
);

// File: tb/shift_cnt_top_test.sv
// Directed bench for shift_cnt_top: one task per scenario.
module shift_cnt_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init = 1'b0;
    logic         mode_i = 1'b0;
    logic [W-1:0] count_o;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [W-1:0] model;

    shift_cnt_top #(.WIDTH(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (init),
        .mode_i  (mode_i),
        .count_o (count_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Next pattern as stated by R1..R5.
    function automatic logic [W-1:0] next_of(logic [W-1:0] s, logic r_n, logic ini, logic m);
        if (!r_n || ini) return 4'b1000;
        return {(m ? ~s[0] : s[0]), s[W-1:1]};
    endfunction

    task automatic check(string req, logic [W-1:0] exp);
        n_run++;
        if (count_o !== exp) begin
            n_fail++;
            $display("FAIL %s: count_o=%b expected=%b", req, count_o, exp);
        end
    endtask

    // One edge with current inputs; model follows; sample at the falling edge.
    task automatic step();
        model = next_of(model, rst_n, init, mode_i);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; init = 1'b0; mode_i = 1'b1;
        step();
        check("R1 reset", 4'b1000);
        rst_n = 1'b1;
    endtask

    task automatic t_ring();
        logic [W-1:0] seq [4] = '{4'b0100, 4'b0010, 4'b0001, 4'b1000};
        init = 1'b1; mode_i = 1'b0; step(); init = 1'b0;
        check("R2 init ring", 4'b1000);
        for (int k = 0; k < 8; k++) begin
            step();
            check("R4 ring seq", seq[k % 4]);
            check("R3 model", model);
        end
    endtask

    task automatic t_twist();
        logic [W-1:0] seq [8] = '{4'b1100, 4'b1110, 4'b1111, 4'b0111,
                                 4'b0011, 4'b0001, 4'b0000, 4'b1000};
        init = 1'b1; mode_i = 1'b1; step(); init = 1'b0;
        check("R2 init twist", 4'b1000);
        for (int k = 0; k < 10; k++) begin
            step();
            check("R5 johnson seq", seq[k % 8]);
        end
    endtask

    task automatic t_init_mid();
        mode_i = 1'b1;
        repeat (3) step();
        init = 1'b1; step(); init = 1'b0;
        check("R2 init mid johnson", 4'b1000);
        mode_i = 1'b0; step(); step();
        init = 1'b1; step(); init = 1'b0;
        check("R2 init mid ring", 4'b1000);
    endtask

    task automatic t_mode_switch();
        init = 1'b1; mode_i = 1'b0; step(); init = 1'b0;
        repeat (3) step();
        check("R6 ring at 0001", 4'b0001);
        mode_i = 1'b1; step();
        check("R6 switch to johnson", 4'b0000);
        step();
        check("R6 johnson continues", 4'b1000);
        mode_i = 1'b0; step();
        check("R6 switch back ring", 4'b0100);
        for (int k = 0; k < 6; k++) begin
            step();
            check("R8 ring ones kept", model);
            n_run++;
            if ($countones(count_o) != 1) begin
                n_fail++;
                $display("FAIL R8: ones=%0d expected=1", $countones(count_o));
            end
        end
    endtask

    task automatic t_stable();
        logic [W-1:0] held;
        held = count_o;
        mode_i = ~mode_i;
        #(CLK_PERIOD/4);
        check("R7 hold after mode change", held);
        init = 1'b1;
        #(CLK_PERIOD/8);
        check("R7 hold after init change", held);
        init = 1'b0;
        rst_n = 1'b0;
        #(CLK_PERIOD/16);
        check("R7 hold after reset change", held);
        rst_n = 1'b1;
        @(negedge clk);
        model = next_of(held, 1'b1, 1'b0, mode_i);
        check("R7 edge after stable", model);
    endtask

    task automatic t_reset_running();
        mode_i = 1'b1;
        repeat (2) step();
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check("R1 reset while running", 4'b1000);
        step();
        check("R5 after reset", 4'b1100);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        model = 4'b1000;
        @(negedge clk);
        t_reset();
        t_ring();
        t_twist();
        t_init_mid();
        t_mode_switch();
        t_stable();
        t_reset_running();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: count_o=%b expected=finish", count_o);
        finish_run();
    end

endmodule